// File: doc/BRIEF.md
# Random Generator Register Interface

This block is the software-facing front end of a random number generator. A 32-bit register bus (write strobe, read strobe, byte address, write data, read data) reaches a control word, a configuration word, a read-only status word and four read-only result words. The block sends commands to the generator core: regulator enable, core reset, macro enable, a start pulse, output mode, instantiate/reseed/update requests, known-answer-test enable and selection, and the clamped reseed interval and length code. It receives the core's ready and health-test flags as plain status pins.

Result words come in on a valid/ready stream. The block takes a 128-bit result only while no earlier result is waiting to be read. `res_ready` is low while the data-valid flag is set. A beat offered then stays with the core until the flag clears. The core must hold `res_data` stable while `res_valid` is high and `res_ready` is low. Read data is combinational from the current state. The side effects of a read take place at the clock edge that ends the read cycle: a data word is cleared to zero, and the data-valid flag may clear.

An error flag records two events. One is the core ready line staying low too long while the macro is enabled. The other is a write that asks for start and known-answer test at the same time. The error flag and the data-valid flag each drive an interrupt through an enable bit.

Top module: `rng_regif`

## Requirements
- R1: Control (address 0x00) stores bits 0,1,2,4,5,8,9,10,24,25,26,30,31 and reads other bits as 0. The start bit is bit 3 and always reads 0. The outputs follow the stored fields: bit0 regulator enable, bit1 core reset (active low), bit2 macro enable, bits5:4 mode, bit8 instantiate, bit9 reseed, bit10 update, bit24 known-answer-test enable, bits26:25 test select, bit30 error interrupt enable, bit31 data-valid interrupt enable.
- R2: A control write with bit 3 set and bit 24 clear drives `start_o` high for exactly the one cycle after the write edge.
- R3: A control write with both bit 3 and bit 24 set produces no start pulse and sets the error flag.
- R4: Configuration (address 0x04) bits 25:0 hold the reseed interval. A written value of 0 or above 2^25 is stored as 2^25 (0x2000000). The reset value is 2^25.
- R5: Configuration bits 31:28 hold the length code. A written code below 4 or above 12 is stored as 12, and the reset value is 12. Bits 27:26 read 0.
- R6: In mode 00 a loaded result fills word 0 (address 0x0C) with `res_data[31:0]` and words 1 to 3 with 0. It sets the data-valid flag (status bit 31), and a read of word 0 clears that flag.
- R7: In modes 01, 10 and 11 a load fills words 0 to 3 (addresses 0x0C, 0x10, 0x14, 0x18) with `res_data` 32-bit slices 0 to 3. The data-valid flag clears at the read that completes reads of all four words, in any order.
- R8: Reading a data word clears it, so a second read of the same word returns 0.
- R9: `res_ready` is 1 exactly while the data-valid flag is 0. A beat offered while `res_ready` is 0 leaves the stored words unchanged.
- R10: While macro enable is 1, the error flag (status bit 30) sets at the edge where core ready has been sampled low at TIMEOUT_CYC+1 consecutive edges. A high sample, or macro enable at 0, restarts the count.
- R11: A control write with bit 30 at 0 clears the error flag, unless the same write sets it (R3).
- R12: `irq_err_o` is the error flag ANDed with control bit 30, and `irq_dv_o` is the data-valid flag ANDed with control bit 31.
- R13: Status (address 0x08) reads regulator ready at bit 0, core ready at bit 1, the start-up, repetition and proportion test passes at bits 4, 5, 6, known-answer pass at bit 27, error at bit 30 and data-valid at bit 31, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| res_valid | input | 1 | Result beat offered by the core |
| res_ready | output | 1 | Result beat accepted at this edge |
| res_data | input | 32*WORDS | Result words, word 0 in the low bits |
| reg_ready_i | input | 1 | Regulator ready |
| core_ready_i | input | 1 | Core ready |
| st_startup_i | input | 1 | Start-up test pass |
| st_repeat_i | input | 1 | Repetition-count test pass |
| st_adapt_i | input | 1 | Adaptive-proportion test pass |
| kat_pass_i | input | 1 | Known-answer test pass |
| reg_en_o | output | 1 | Regulator enable |
| core_rst_n_o | output | 1 | Core reset, active low |
| macro_en_o | output | 1 | Macro enable |
| start_o | output | 1 | One-cycle start command |
| mode_o | output | 2 | Output mode |
| inst_o | output | 1 | Instantiate request |
| reseed_o | output | 1 | Reseed request |
| update_o | output | 1 | Update request |
| kat_en_o | output | 1 | Known-answer test enable |
| kat_sel_o | output | 2 | Known-answer test select |
| reseed_ivl_o | output | IVL_W | Clamped reseed interval |
| len_code_o | output | LEN_W | Clamped length code |
| irq_err_o | output | 1 | Error interrupt |
| irq_dv_o | output | 1 | Data-valid interrupt |

## Verification
Register reads are combinational, so the bench samples `bus_rdata` 1 ns after it drives the address, inside the read cycle. It looks for read side effects (cleared word, cleared flag) in a later read. A write, a stream handshake or a timeout sample takes effect at the next rising edge. The bench therefore samples `start_o`, the interrupts, `res_ready` and the configuration outputs at the falling edge that follows, and it checks that `start_o` is low again one falling edge later. For the ready-loss timer the bench counts falling edges after it drops core ready. It expects the error to stay low after TIMEOUT_CYC edges and to show after edge TIMEOUT_CYC+1.

// File: rtl/rng_regif_pkg.sv
package rng_regif_pkg;
  localparam int unsigned A_CTL = 0;
  localparam int unsigned A_CFG = 4;
  localparam int unsigned A_STS = 8;
  localparam int unsigned A_DAT = 12;

  localparam logic [31:0] CTL_KEEP = 32'hC700_0737;

  localparam int B_REGEN  = 0;
  localparam int B_CRST   = 1;
  localparam int B_MACRO  = 2;
  localparam int B_START  = 3;
  localparam int B_MODE   = 4;
  localparam int B_INST   = 8;
  localparam int B_RESEED = 9;
  localparam int B_UPDATE = 10;
  localparam int B_KAT    = 24;
  localparam int B_KSEL   = 25;
  localparam int B_ERRIE  = 30;
  localparam int B_DVIE   = 31;

  typedef enum logic [1:0] {
    MODE_RAW    = 2'b00,
    MODE_NONDET = 2'b01,
    MODE_DET    = 2'b10,
    MODE_RSVD   = 2'b11
  } rng_mode_e;
endpackage

// File: rtl/rng_ctl_cfg.sv
module rng_ctl_cfg
  import rng_regif_pkg::*;
#(
  parameter int IVL_W   = 26,
  parameter int LEN_W   = 4,
  parameter int LEN_MIN = 4,
  parameter int LEN_MAX = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic        cfg_wr,
  input  logic [31:0] wdata,
  output logic [31:0] ctl_q,
  output logic [31:0] cfg_q,
  output logic        start_o,
  output logic        conflict_o
);
  localparam int LEN_LSB = 32 - LEN_W;
  localparam logic [IVL_W-1:0] IVL_MAX = {1'b1, {(IVL_W-1){1'b0}}};
  localparam logic [LEN_W-1:0] LEN_HI  = LEN_W'(LEN_MAX);
  localparam logic [LEN_W-1:0] LEN_LO  = LEN_W'(LEN_MIN);
  localparam logic [31:0] CFG_RST = (32'(LEN_HI) << LEN_LSB) | 32'(IVL_MAX);

  logic [IVL_W-1:0] ivl_in;
  logic [LEN_W-1:0] len_in;
  logic             ivl_ok, len_ok;
  logic [31:0]      cfg_next;

  always_comb begin
    ivl_in   = wdata[IVL_W-1:0];
    len_in   = wdata[31:LEN_LSB];
    ivl_ok   = (ivl_in != '0) && (ivl_in <= IVL_MAX);
    len_ok   = (len_in >= LEN_LO) && (len_in <= LEN_HI);
    cfg_next = '0;
    cfg_next[IVL_W-1:0] = ivl_ok ? ivl_in : IVL_MAX;
    cfg_next[31:LEN_LSB] = len_ok ? len_in : LEN_HI;
  end

  assign conflict_o = ctl_wr && wdata[B_START] && wdata[B_KAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      cfg_q   <= CFG_RST;
      start_o <= 1'b0;
    end else begin
      start_o <= ctl_wr && wdata[B_START] && !wdata[B_KAT];
      if (ctl_wr) ctl_q <= wdata & CTL_KEEP;
      if (cfg_wr) cfg_q <= cfg_next;
    end
  end

  // R2: start never lasts two cycles without a fresh write
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_o && !$past(ctl_wr) |-> 1'b0 || !start_o);
  a_r2_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && !ctl_wr) |=> !start_o);
  // R3: a start request combined with test enable gives no pulse
  a_r3_no_start_on_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_o |=> !start_o);
  // R4: the stored interval stays in its legal range after a write
  a_r4_ivl_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_q[IVL_W-1:0] != '0) && (cfg_q[IVL_W-1:0] <= IVL_MAX));
  // R5: the stored length code stays in its legal range after a write
  a_r5_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_q[31:LEN_LSB] >= LEN_LO) && (cfg_q[31:LEN_LSB] <= LEN_HI));
endmodule

// File: rtl/rng_err_timer.sv
module rng_err_timer #(
  parameter int TIMEOUT_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic core_ready,
  input  logic conflict,
  input  logic clr,
  output logic err_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt_q;
  logic          low_run, hit;

  assign low_run = en && !core_ready;
  assign hit     = low_run && (cnt_q == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_o <= 1'b0;
    end else begin
      if (!low_run)        cnt_q <= '0;
      else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
      if (hit || conflict) err_o <= 1'b1;
      else if (clr)        err_o <= 1'b0;
    end
  end

  // R10: the flag rises only from a timeout or a conflicting write
  a_r10_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> ($past(conflict) || $past(low_run)));
  // R11: the flag falls only on a clearing write
  a_r11_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_o) |-> $past(clr));
endmodule

// File: rtl/rng_data_store.sv
module rng_data_store #(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  parameter int IDX_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                res_valid,
  output logic                res_ready,
  input  logic [WORDS*DW-1:0] res_data,
  input  logic                wide,
  input  logic                rd_en,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [WORDS*DW-1:0] words_flat,
  output logic                dv_o
);
  localparam logic [WORDS-1:0] ALL = '1;

  logic [DW-1:0]    words_q [WORDS];
  logic [WORDS-1:0] seen_q, rd_hot;
  logic             wide_q, load, done;

  assign res_ready = !dv_o;
  assign load      = res_valid && res_ready;

  always_comb begin
    rd_hot = '0;
    for (int i = 0; i < WORDS; i++)
      if (rd_en && rd_idx == IDX_W'(i)) rd_hot[i] = 1'b1;
    done = wide_q ? ((seen_q | rd_hot) == ALL) : rd_hot[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_o   <= 1'b0;
      wide_q <= 1'b0;
      seen_q <= '0;
    end else if (load) begin
      dv_o   <= 1'b1;
      wide_q <= wide;
      seen_q <= '0;
    end else if (dv_o) begin
      seen_q <= seen_q | rd_hot;
      if (done) dv_o <= 1'b0;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        words_q[g] <= '0;
      else if (load)     words_q[g] <= (g == 0 || wide) ? res_data[g*DW +: DW] : '0;
      else if (rd_hot[g]) words_q[g] <= '0;
    end
    assign words_flat[g*DW +: DW] = words_q[g];
  end

  // R9: held data is not overwritten while it waits to be read
  a_r9_hold_while_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_o && !rd_en) |=> $stable(words_flat));
  // R6 / R7: the valid flag only drops after a data read
  a_r7_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dv_o) |-> $past(rd_en));
  // R8: a read word holds zero afterwards unless a load intervened
  a_r8_read_once: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == '0 && !load) |=> words_flat[DW-1:0] == '0);
endmodule

// File: rtl/rng_regif.sv
module rng_regif
  import rng_regif_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int WORDS       = 4,
  parameter int IVL_W       = 26,
  parameter int LEN_W       = 4,
  parameter int TIMEOUT_CYC = 50000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic                 res_valid,
  output logic                 res_ready,
  input  logic [32*WORDS-1:0]  res_data,
  input  logic                 reg_ready_i,
  input  logic                 core_ready_i,
  input  logic                 st_startup_i,
  input  logic                 st_repeat_i,
  input  logic                 st_adapt_i,
  input  logic                 kat_pass_i,
  output logic                 reg_en_o,
  output logic                 core_rst_n_o,
  output logic                 macro_en_o,
  output logic                 start_o,
  output logic [1:0]           mode_o,
  output logic                 inst_o,
  output logic                 reseed_o,
  output logic                 update_o,
  output logic                 kat_en_o,
  output logic [1:0]           kat_sel_o,
  output logic [IVL_W-1:0]     reseed_ivl_o,
  output logic [LEN_W-1:0]     len_code_o,
  output logic                 irq_err_o,
  output logic                 irq_dv_o
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] AD_CTL = ADDR_W'(A_CTL);
  localparam logic [ADDR_W-1:0] AD_CFG = ADDR_W'(A_CFG);
  localparam logic [ADDR_W-1:0] AD_STS = ADDR_W'(A_STS);
  localparam logic [ADDR_W-1:0] AD_DAT = ADDR_W'(A_DAT);
  localparam logic [ADDR_W-1:0] DAT_SPAN = ADDR_W'(4 * WORDS);

  logic [31:0]         ctl_q, cfg_q, sts;
  logic [32*WORDS-1:0] words_flat;
  logic [ADDR_W-1:0]   off;
  logic                dat_hit, conflict, err_q, dv_q, ctl_wr;
  rng_mode_e           mode;

  assign ctl_wr  = bus_wr && bus_addr == AD_CTL;
  assign off     = bus_addr - AD_DAT;
  assign dat_hit = (bus_addr >= AD_DAT) && (off < DAT_SPAN) && (off[1:0] == 2'b00);
  assign mode    = rng_mode_e'(ctl_q[B_MODE +: 2]);

  rng_ctl_cfg #(.IVL_W(IVL_W), .LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
    .cfg_wr(bus_wr && bus_addr == AD_CFG), .wdata(bus_wdata),
    .ctl_q(ctl_q), .cfg_q(cfg_q), .start_o(start_o), .conflict_o(conflict)
  );

  rng_err_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .en(ctl_q[B_MACRO]), .core_ready(core_ready_i),
    .conflict(conflict), .clr(ctl_wr && !bus_wdata[B_ERRIE]), .err_o(err_q)
  );

  rng_data_store #(.WORDS(WORDS), .DW(32), .IDX_W(IDX_W)) u_dat (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .wide(mode != MODE_RAW), .rd_en(bus_rd && dat_hit),
    .rd_idx(off[ADDR_W-1:2]), .words_flat(words_flat), .dv_o(dv_q)
  );

  assign sts = {dv_q, err_q, 2'b00, kat_pass_i, 20'd0, st_adapt_i, st_repeat_i,
                st_startup_i, 2'b00, core_ready_i, reg_ready_i};

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AD_CTL)      bus_rdata = ctl_q;
    else if (bus_addr == AD_CFG) bus_rdata = cfg_q;
    else if (bus_addr == AD_STS) bus_rdata = sts;
    else if (dat_hit) begin
      for (int i = 0; i < WORDS; i++)
        if (off[ADDR_W-1:2] == IDX_W'(i)) bus_rdata = words_flat[i*32 +: 32];
    end
  end

  assign reg_en_o     = ctl_q[B_REGEN];
  assign core_rst_n_o = ctl_q[B_CRST];
  assign macro_en_o   = ctl_q[B_MACRO];
  assign mode_o       = mode;
  assign inst_o       = ctl_q[B_INST];
  assign reseed_o     = ctl_q[B_RESEED];
  assign update_o     = ctl_q[B_UPDATE];
  assign kat_en_o     = ctl_q[B_KAT];
  assign kat_sel_o    = ctl_q[B_KSEL +: 2];
  assign reseed_ivl_o = cfg_q[IVL_W-1:0];
  assign len_code_o   = cfg_q[31 -: LEN_W];
  assign irq_err_o    = err_q && ctl_q[B_ERRIE];
  assign irq_dv_o     = dv_q && ctl_q[B_DVIE];

  // R12: interrupts never assert without their enable bits
  a_r12_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_err_o |-> ctl_q[B_ERRIE]) and (irq_dv_o |-> ctl_q[B_DVIE]));
  // R3: a conflicting control write raises the error flag
  a_r3_conflict_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> err_q);
endmodule

// File: tb/rng_regif_tb_top.sv
`timescale 1ns/1ps
module rng_regif_tb_top;
  localparam int TO = 8;
  localparam logic [4:0] ACTL = 5'h00, ACFG = 5'h04, ASTS = 5'h08;
  localparam logic [4:0] AW0 = 5'h0C, AW1 = 5'h10, AW2 = 5'h14, AW3 = 5'h18;
  localparam int NV = 9;
  localparam logic [31:0] CFG_IN [NV] = '{32'h4000_0001, 32'hC200_0000, 32'h5000_0000,
    32'h7200_0001, 32'h3000_0010, 32'hD000_0010, 32'hF3FF_FFFF, 32'h0C00_0005, 32'h6123_4567};
  localparam logic [31:0] CFG_EXP [NV] = '{32'h4000_0001, 32'hC200_0000, 32'h5200_0000,
    32'h7200_0000, 32'hC000_0010, 32'hC000_0010, 32'hC200_0000, 32'hC000_0005, 32'h6123_4567};

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic res_valid = 0, res_ready;
  logic [127:0] res_data = '0;
  logic reg_ready_i = 0, core_ready_i = 1, st_startup_i = 0, st_repeat_i = 0;
  logic st_adapt_i = 0, kat_pass_i = 0;
  logic reg_en_o, core_rst_n_o, macro_en_o, start_o, inst_o, reseed_o, update_o, kat_en_o;
  logic [1:0] mode_o, kat_sel_o;
  logic [25:0] reseed_ivl_o;
  logic [3:0] len_code_o;
  logic irq_err_o, irq_dv_o;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  rng_regif #(.TIMEOUT_CYC(TO)) dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic offer(logic [127:0] d);
    res_valid = 1; res_data = d;
    @(negedge clk);
    res_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    rd(ACTL, v); chk("R1 reset ctl", v, 32'h0);
    rd(ACFG, v); chk("R4 reset cfg", v, 32'hC200_0000);
    chk("R5 reset len", 32'(len_code_o), 32'd12);
    chk("R9 reset ready", 32'(res_ready), 32'd1);
    chk("R12 reset irq", {30'd0, irq_err_o, irq_dv_o}, 32'd0);

    // configuration clamping table (R4, R5)
    for (int i = 0; i < NV; i++) begin
      wr(ACFG, CFG_IN[i]);
      rd(ACFG, v);
      chk("R4/R5 cfg clamp", v, CFG_EXP[i]);
    end
    chk("R4 ivl port", 32'(reseed_ivl_o), 32'h0123_4567);
    chk("R5 len port", 32'(len_code_o), 32'd6);

    // control fields and start pulse
    wr(ACTL, 32'hFEFF_FFFF);
    chk("R2 start high", 32'(start_o), 32'd1);
    chk("R1 outputs", {18'd0, reg_en_o, core_rst_n_o, macro_en_o, mode_o, inst_o,
        reseed_o, update_o, kat_en_o, kat_sel_o, 3'd0}, {18'd0, 3'b111, 2'b11, 3'b111, 1'b0, 2'b11, 3'd0});
    @(negedge clk);
    chk("R2 start one cycle", 32'(start_o), 32'd0);
    rd(ACTL, v); chk("R1 ctl readback", v, 32'hC600_0737);
    wr(ACTL, 32'h0);

    // conflict (R3), interrupt gating (R12), clear (R11)
    wr(ACTL, 32'h0100_0008);
    chk("R3 no start", 32'(start_o), 32'd0);
    rd(ASTS, v); chk("R3 err set", 32'(v[30]), 32'd1);
    chk("R12 err irq masked", 32'(irq_err_o), 32'd0);
    wr(ACTL, 32'h4000_0000);
    chk("R12 err irq", 32'(irq_err_o), 32'd1);
    wr(ACTL, 32'h0);
    rd(ASTS, v); chk("R11 err cleared", 32'(v[30]), 32'd0);

    // status map (R13)
    reg_ready_i = 1; st_startup_i = 1; st_adapt_i = 1; kat_pass_i = 1;
    rd(ASTS, v); chk("R13 status map", v, 32'h0800_0053);
    reg_ready_i = 0; st_startup_i = 0; st_adapt_i = 0; kat_pass_i = 0; st_repeat_i = 1;
    rd(ASTS, v); chk("R13 repeat bit", v, 32'h0000_0022);
    st_repeat_i = 0;

    // raw mode (R6, R8)
    wr(ACTL, 32'h0000_0004);
    offer(128'h4444_4444_3333_3333_2222_2222_1111_1111);
    rd(ASTS, v); chk("R6 dv set", 32'(v[31]), 32'd1);
    chk("R12 dv irq masked", 32'(irq_dv_o), 32'd0);
    rd(AW1, v); chk("R6 narrow word1", v, 32'h0);
    rd(ASTS, v); chk("R6 dv held", 32'(v[31]), 32'd1);
    rd(AW0, v); chk("R6 word0", v, 32'h1111_1111);
    rd(ASTS, v); chk("R6 dv cleared", 32'(v[31]), 32'd0);
    rd(AW0, v); chk("R8 read once", v, 32'h0);

    // nondeterministic mode (R7, R9, R12)
    wr(ACTL, 32'h8000_0014);
    offer(128'hA3A3_A3A3_A2A2_A2A2_A1A1_A1A1_A0A0_A0A0);
    chk("R12 dv irq", 32'(irq_dv_o), 32'd1);
    chk("R9 ready low", 32'(res_ready), 32'd0);
    offer(128'hB3B3_B3B3_B2B2_B2B2_B1B1_B1B1_B0B0_B0B0);
    rd(AW2, v); chk("R9 word2 kept", v, 32'hA2A2_A2A2);
    rd(AW0, v); chk("R7 word0", v, 32'hA0A0_A0A0);
    rd(AW3, v); chk("R7 word3", v, 32'hA3A3_A3A3);
    rd(ASTS, v); chk("R7 dv held", 32'(v[31]), 32'd1);
    rd(AW1, v); chk("R7 word1", v, 32'hA1A1_A1A1);
    chk("R7 dv irq gone", 32'(irq_dv_o), 32'd0);
    rd(AW2, v); chk("R8 word2 once", v, 32'h0);
    chk("R9 ready back", 32'(res_ready), 32'd1);

    // deterministic mode (R7)
    wr(ACTL, 32'h0000_0024);
    chk("R1 mode out", 32'(mode_o), 32'd2);
    offer(128'hC3C3_C3C3_C2C2_C2C2_C1C1_C1C1_C0C0_C0C0);
    rd(AW3, v); chk("R7 det word3", v, 32'hC3C3_C3C3);
    rd(AW1, v); rd(AW0, v);
    rd(ASTS, v); chk("R7 det dv held", 32'(v[31]), 32'd1);
    rd(AW2, v); chk("R7 det word2", v, 32'hC2C2_C2C2);
    rd(ASTS, v); chk("R7 det dv cleared", 32'(v[31]), 32'd0);

    // ready-loss timer (R10, R11)
    wr(ACTL, 32'h4000_0000);
    core_ready_i = 0;
    repeat (3 * TO) @(negedge clk);
    chk("R10 no timeout when macro off", 32'(irq_err_o), 32'd0);
    wr(ACTL, 32'h4000_0004);
    repeat (TO - 3) @(negedge clk);
    core_ready_i = 1;
    @(negedge clk);
    core_ready_i = 0;
    repeat (TO) @(negedge clk);
    chk("R10 not yet", 32'(irq_err_o), 32'd0);
    @(negedge clk);
    chk("R10 timeout", 32'(irq_err_o), 32'd1);
    core_ready_i = 1;
    wr(ACTL, 32'h0000_0004);
    rd(ASTS, v); chk("R11 timeout cleared", 32'(v[30]), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule